// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time (hours, minutes, seconds) and a calendar date (century, year, month, day of week, day of month). Every field is packed BCD. The counter is advanced by a single-cycle one-second tick strobe supplied from outside. Hours count in 24-hour form. Days of the month roll over at 28, 29, 30 or 31 according to the month. February has 29 days whenever the two-digit year is a multiple of four. December 31 rolls into a new year, and year 99 carries into the century field. The day of week cycles 1 to 7 and then wraps back to 1.

Software reaches the block through a plain register port. It has a write strobe, a word address, write data and combinational read data. Setting a new time or date follows a fixed handshake:

1. Software sets one or both freeze-request bits. Each bit stops its own domain from counting.
2. The block raises an acknowledge flag on the next second tick.
3. Software writes the new values.
4. Software drops the request bits. Counting resumes from the written values on the next tick.

Sticky status flags report the acknowledge, each tick, each minute change and each day change. Writing 1s to a clear register removes flags.

Top module: `bcd_clock_cal`

## Requirements
- R1: After reset:
  - time reads 00:00:00;
  - the date word holds century 19, year 00, month 01, day of week 1, day of month 01;
  - control and status read 0.
- R2: The time word at address 1 holds seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16, and bit 22 always reads 0. Counting behaves as follows:
  - each unfrozen tick adds one second;
  - seconds 59 wrap to 00 and advance the minute;
  - minutes 59 wrap to 00 and advance the hour;
  - 23:59:59 wraps to 00:00:00.
- R3: The date word at address 2 holds century in 6:0, year in 15:8, month in 20:16, day of week in 23:21 and day of month in 29:24. A day carry from the time domain moves day of month past the month's last day back to 01 and advances the month; December wraps to January. Month lengths are:
  - 31 days for months 1, 3, 5, 7, 8, 10 and 12;
  - 30 days for months 4, 6, 9 and 11;
  - 29 days for February when the year is a multiple of four, otherwise 28.
- R4: On each day advance, day of week steps from 7 back to 1 and otherwise increases by one. Year 99 rolls to 00 and increments the century.
- R5: Control at address 0 has bit 0 to freeze time and bit 1 to freeze the date.
  - A frozen domain does not count.
  - A write to the time or date word takes effect only while that domain's freeze bit is set; otherwise it leaves the word unchanged.
- R6: Status at address 3, bit 0 (acknowledge), is set on any tick while either freeze bit is set. It stays set until cleared, and is never set on a tick with both freeze bits clear.
- R7: Status bits are set as follows:
  - bit 2 on every tick;
  - bit 3 when the minute advances by counting;
  - bit 4 when the date advances by counting.
- R8: Writing address 4 clears every status bit whose data bit is 1. A set event arriving in the same cycle as its clear wins.
- R9: After the freeze bits are dropped, the next tick continues from the values written during the freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe per second |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address (0 control, 1 time, 2 date, 3 status, 4 status clear) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |

## Verification
Each month's last day at 23:59:58 is loaded through the full handshake, in both a leap and a non-leap year. Two ticks then show the last second of the day and the rollover. This separates 28-, 29-, 30- and 31-day handling, the December-to-January year step and the day-of-week wrap. A Dec 31 of year 99 case exercises the century carry.

A run of over an hour of consecutive ticks is compared against a seconds counter kept in the bench. This covers every seconds and minutes carry.

Further short sequences cover the following:
- freezing one domain while the other crosses midnight;
- writes attempted without a freeze;
- clear-versus-set collisions on the status flags.

// File: rtl/bcd_clock_cal_pkg.sv
package bcd_clock_cal_pkg;

  localparam int WORD_W = 32;
  localparam int STAT_W = 5;

  localparam int ST_ACK  = 0;
  localparam int ST_SEC  = 2;
  localparam int ST_MIN  = 3;
  localparam int ST_DAY  = 4;

  // two BCD digits to binary
  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  // binary 0..99 to two BCD digits
  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    logic [6:0] tens;
    tens = v / 7'd10;
    return {tens[3:0], 4'(v - tens * 7'd10)};
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_time_ctr.sv
module bcd_time_ctr
  import bcd_clock_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       load,
  input  logic [6:0] load_sec,
  input  logic [6:0] load_min,
  input  logic [5:0] load_hour,
  output logic [6:0] sec_q,
  output logic [6:0] min_q,
  output logic [5:0] hour_q,
  output logic       min_carry,
  output logic       day_carry
);

  logic [6:0] sec_b, min_b, hour_b;
  logic [7:0] sec_n, min_n, hour_n;
  logic       sec_last, min_last, hour_last;

  always_comb begin
    sec_b     = bcd2bin({1'b0, sec_q});
    min_b     = bcd2bin({1'b0, min_q});
    hour_b    = bcd2bin({2'b0, hour_q});
    sec_last  = (sec_b == 7'd59);
    min_last  = (min_b == 7'd59);
    hour_last = (hour_b == 7'd23);
    sec_n     = sec_last  ? 8'h00 : bin2bcd(sec_b + 7'd1);
    min_n     = min_last  ? 8'h00 : bin2bcd(min_b + 7'd1);
    hour_n    = hour_last ? 8'h00 : bin2bcd(hour_b + 7'd1);
  end

  assign min_carry = run & sec_last;
  assign day_carry = min_carry & min_last & hour_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
    end else if (load) begin
      sec_q  <= load_sec;
      min_q  <= load_min;
      hour_q <= load_hour;
    end else if (run) begin
      sec_q <= sec_n[6:0];
      if (sec_last) begin
        min_q <= min_n[6:0];
        if (min_last) hour_q <= hour_n[5:0];
      end
    end
  end

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (min_carry && !load) |=> (sec_q == 7'h00));
  p_midnight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && !load) |=> (hour_q == 6'h00 && min_q == 7'h00));

endmodule

// File: rtl/bcd_cal_ctr.sv
module bcd_cal_ctr
  import bcd_clock_cal_pkg::*;
#(
  parameter logic [6:0] RST_CENT = 7'h19
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance,
  input  logic       load,
  input  logic [6:0] load_cent,
  input  logic [7:0] load_year,
  input  logic [4:0] load_mon,
  input  logic [2:0] load_dow,
  input  logic [5:0] load_date,
  output logic [6:0] cent_q,
  output logic [7:0] year_q,
  output logic [4:0] mon_q,
  output logic [2:0] dow_q,
  output logic [5:0] date_q
);

  logic [6:0] date_b, mon_b, year_b, cent_b;
  logic [7:0] date_n, mon_n, year_n, cent_n;
  logic       last_day, last_mon, last_year;

  always_comb begin
    date_b    = bcd2bin({2'b0, date_q});
    mon_b     = bcd2bin({3'b0, mon_q});
    year_b    = bcd2bin(year_q);
    cent_b    = bcd2bin({1'b0, cent_q});
    last_day  = ({2'b0, date_b[4:0]} == date_b) &&
                (date_b[4:0] == month_days(mon_b[3:0], year_b[1:0] == 2'd0));
    last_mon  = (mon_b == 7'd12);
    last_year = (year_b == 7'd99);
    date_n    = bin2bcd(date_b + 7'd1);
    mon_n     = last_mon  ? 8'h01 : bin2bcd(mon_b + 7'd1);
    year_n    = last_year ? 8'h00 : bin2bcd(year_b + 7'd1);
    cent_n    = bin2bcd(cent_b + 7'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cent_q <= RST_CENT;
      year_q <= 8'h00;
      mon_q  <= 5'h01;
      dow_q  <= 3'd1;
      date_q <= 6'h01;
    end else if (load) begin
      cent_q <= load_cent;
      year_q <= load_year;
      mon_q  <= load_mon;
      dow_q  <= load_dow;
      date_q <= load_date;
    end else if (advance) begin
      dow_q <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
      if (!last_day) begin
        date_q <= date_n[5:0];
      end else begin
        date_q <= 6'h01;
        mon_q  <= mon_n[4:0];
        if (last_mon) begin
          year_q <= year_n;
          if (last_year) cent_q <= cent_n[6:0];
        end
      end
    end
  end

  p_date_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && last_day) |=> (date_q == 6'h01));
  p_dow_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && dow_q == 3'd7) |=> (dow_q == 3'd1));

endmodule

// File: rtl/bcd_clock_cal.sv
module bcd_clock_cal
  import bcd_clock_cal_pkg::*;
#(
  parameter int         ADDR_W   = 3,
  parameter logic [6:0] RST_CENT = 7'h19
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(4);

  logic [1:0]        ctrl_q;
  logic [STAT_W-1:0] stat_q, stat_set, stat_clr;

  logic [6:0] sec, min, cent;
  logic [5:0] hour, date;
  logic [7:0] year;
  logic [4:0] mon;
  logic [2:0] dow;

  // named internal events
  logic time_run, time_load, cal_adv, cal_load, min_evt, day_carry, ack_evt;
  logic [WORD_W-1:0] time_word, date_word;

  assign time_run  = sec_tick & ~ctrl_q[0];
  assign time_load = bus_wr & (bus_addr == A_TIME) & ctrl_q[0];
  assign cal_load  = bus_wr & (bus_addr == A_DATE) & ctrl_q[1];
  assign cal_adv   = day_carry & ~ctrl_q[1];
  assign ack_evt   = sec_tick & (|ctrl_q);

  bcd_time_ctr u_time (
    .clk(clk), .rst_n(rst_n), .run(time_run), .load(time_load),
    .load_sec(bus_wdata[6:0]), .load_min(bus_wdata[14:8]), .load_hour(bus_wdata[21:16]),
    .sec_q(sec), .min_q(min), .hour_q(hour),
    .min_carry(min_evt), .day_carry(day_carry)
  );

  bcd_cal_ctr #(.RST_CENT(RST_CENT)) u_cal (
    .clk(clk), .rst_n(rst_n), .advance(cal_adv), .load(cal_load),
    .load_cent(bus_wdata[6:0]), .load_year(bus_wdata[15:8]), .load_mon(bus_wdata[20:16]),
    .load_dow(bus_wdata[23:21]), .load_date(bus_wdata[29:24]),
    .cent_q(cent), .year_q(year), .mon_q(mon), .dow_q(dow), .date_q(date)
  );

  always_comb begin
    stat_set          = '0;
    stat_set[ST_ACK]  = ack_evt;
    stat_set[ST_SEC]  = sec_tick;
    stat_set[ST_MIN]  = min_evt;
    stat_set[ST_DAY]  = cal_adv;
    stat_clr = (bus_wr && bus_addr == A_CLR) ? bus_wdata[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata[1:0];
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  assign time_word = {9'b0, 1'b0, hour, 1'b0, min, 1'b0, sec};
  assign date_word = {2'b0, date, dow, mon, year, 1'b0, cent};

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {30'b0, ctrl_q};
      A_TIME:  bus_rdata = time_word;
      A_DATE:  bus_rdata = date_word;
      A_STAT:  bus_rdata = {{(WORD_W-STAT_W){1'b0}}, stat_q};
      default: bus_rdata = '0;
    endcase
  end

  p_time_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && !(bus_wr && bus_addr == A_TIME)) |=> $stable(time_word));
  p_date_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && !(bus_wr && bus_addr == A_DATE)) |=> $stable(date_word));
  p_ack_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && ctrl_q != 2'b00) |=> stat_q[ST_ACK]);
  p_tick_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> stat_q[ST_SEC]);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR && bus_wdata[ST_SEC] && !sec_tick) |=> !stat_q[ST_SEC]);

endmodule

// File: tb/bcd_clock_cal_tb_top.sv
module bcd_clock_cal_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  bcd_clock_cal dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] bc(input int v);
    return 32'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic logic [31:0] tpack(input int h, input int m, input int s);
    return (bc(h) << 16) | (bc(m) << 8) | bc(s);
  endfunction

  function automatic logic [31:0] cpack(input int c, input int y, input int mo, input int dw, input int d);
    return (bc(d) << 24) | (32'(dw) << 21) | (bc(mo) << 16) | (bc(y) << 8) | bc(c);
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 3'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  // full handshake: freeze both, wait ack, write, clear flags, release
  task automatic load(input logic [31:0] t, input logic [31:0] c);
    logic [31:0] v;
    wr(0, 32'h3);
    tick();
    rd(3, v);
    chk("R6 ack after freeze", v & 32'h1, 32'h1);
    wr(1, t);
    wr(2, c);
    wr(4, 32'h1f);
    wr(0, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 control", v, 32'h0);
    rd(1, v); chk("R1 time", v, tpack(0, 0, 0));
    rd(2, v); chk("R1 date", v, cpack(19, 0, 1, 1, 1));
    rd(3, v); chk("R1 status", v, 32'h0);

    // R3 R4 month-end sweep, non-leap and leap year
    for (int yy = 23; yy <= 24; yy++) begin
      for (int m = 1; m <= 12; m++) begin
        int dw, dim, nm, ny, nd;
        dw  = (m % 7) + 1;
        dim = mdays(m, yy);
        load(tpack(23, 59, 58), cpack(20, yy, m, dw, dim));
        tick();
        rd(1, v); chk("R9 resume from written time", v, tpack(23, 59, 59));
        rd(2, v); chk("R3 date kept before midnight", v, cpack(20, yy, m, dw, dim));
        tick();
        nm = (m == 12) ? 1 : m + 1;
        ny = (m == 12) ? yy + 1 : yy;
        nd = (dw == 7) ? 1 : dw + 1;
        rd(1, v); chk("R2 midnight wrap", v, tpack(0, 0, 0));
        rd(2, v); chk("R3 R4 month rollover", v, cpack(20, ny, nm, nd, 1));
        rd(3, v); chk("R7 tick minute day flags", v, 32'h1c);
      end
    end

    // R3 leap February 28 -> 29
    load(tpack(23, 59, 59), cpack(20, 24, 2, 7, 28));
    tick();
    rd(2, v); chk("R3 leap feb 29", v, cpack(20, 24, 2, 1, 29));

    // R4 century carry
    load(tpack(23, 59, 59), cpack(19, 99, 12, 3, 31));
    tick();
    rd(2, v); chk("R4 century carry", v, cpack(20, 0, 1, 4, 1));

    // R2 long run of consecutive seconds
    load(tpack(0, 0, 0), cpack(20, 25, 6, 1, 10));
    s = 0;
    for (int i = 0; i < 3700; i++) begin
      tick();
      s++;
      rd(1, v);
      chk("R2 counting", v, tpack(s / 3600, (s / 60) % 60, s % 60));
    end
    rd(1, v); chk("R2 bit22 zero", v & 32'h0040_0000, 32'h0);

    // R5 writes ignored without freeze
    load(tpack(10, 20, 30), cpack(20, 25, 3, 2, 15));
    wr(1, tpack(12, 34, 56));
    rd(1, v); chk("R5 time write ignored", v, tpack(10, 20, 30));
    wr(2, cpack(20, 1, 1, 1, 1));
    rd(2, v); chk("R5 date write ignored", v, cpack(20, 25, 3, 2, 15));

    // R5 time freeze, R6 ack sticky
    wr(4, 32'h1f);
    wr(0, 32'h1);
    tick(); tick(); tick();
    rd(1, v); chk("R5 time frozen", v, tpack(10, 20, 30));
    rd(3, v); chk("R6 ack sticky", v & 32'h1, 32'h1);
    wr(0, 32'h0);

    // R5 date freeze while time crosses midnight
    load(tpack(23, 59, 59), cpack(20, 25, 3, 2, 15));
    wr(0, 32'h2);
    tick();
    rd(1, v); chk("R5 time runs under date freeze", v, tpack(0, 0, 0));
    rd(2, v); chk("R5 date frozen", v, cpack(20, 25, 3, 2, 15));
    rd(3, v); chk("R7 no day flag when frozen", v & 32'h10, 32'h0);
    wr(0, 32'h0);

    // R8 clear and set-wins; R6 no ack with no request
    wr(4, 32'h1f);
    tick();
    rd(3, v); chk("R6 R7 only tick flag", v, 32'h04);
    wr(4, 32'h04);
    rd(3, v); chk("R8 clear", v, 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h04; sec_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; sec_tick = 1'b0;
    rd(3, v); chk("R8 set wins over clear", v, 32'h04);

    finish_run();
  end

endmodule